// File: doc/BRIEF.md
# DC-Null Sign Assignment Unit

This unit finishes a PCM transmit frame of six signalling intervals. It takes six unsigned 7-bit mu-law magnitude codes, one for each interval, and the six mapper indices those codes came from. It also takes a small group of user sign bits. Part of the frame carries user data in its signs. The remaining intervals have their signs chosen so that the long-run average of the transmitted line signal is pushed back toward zero.

When a frame is accepted, the unit differentially encodes the user sign bits. The encoder state carries from one frame to the next. The unit picks the compensation intervals from the mapper indices and steers the encoded user signs into the free intervals. It then emits the six signed octets, one per clock. A running sum of the linear value of every emitted code gives the sign of each compensation interval. The sum is updated after each octet, so a compensation interval late in the frame sees the codes sent earlier in the same frame.

Top module: `dcs_sign_unit`

## Requirements
- R1: A frame is accepted on a clock edge where `frame_valid` is high and `pcm_valid` is low. The six octets appear with `pcm_valid` high on the six following cycles, with `pcm_slot` counting 0 to 5. `pcm_valid` then drops, and `frame_valid` is ignored while `pcm_valid` is high.
- R2: Octet bits 6..0 equal the magnitude code of the current slot, taken from `frame_mag[7*i+6:7*i]` for slot i. Bit 7 is the sign, where 1 means positive.
- R3: User sign j is encoded as e_j = u_j XOR e_(j-1), with `user_signs[0]` as the first bit. e_(-1) is the last encoded user sign of the previous accepted frame that had at least one user sign. It is 0 after reset.
- R4: Encoded user signs e_0, e_1, ... go to the non-compensation slots in ascending slot order.
- R5: With S = `user_count` (0..6), exactly 6-S slots are compensation slots. These are the slots with the smallest indices in `frame_idx[8*i+7:8*i]`, and among equal indices the higher slot number is taken first. `pcm_comp` is high exactly while such a slot is output.
- R6: A compensation slot's sign is opposite to the sign of `run_sum` while that slot is output. A sum of zero counts as non-negative, so the compensation sign is negative.
- R7: A code with segment e = bits 6..4 and step q = bits 3..0 has the linear value ((2q+33)<<e)-33. Each emitted octet adds plus or minus that value to `run_sum` at the clock edge that ends its cycle. `run_sum` changes at no other time.
- R8: `run_sum` is a signed 24-bit value that saturates at +8388607 and -8388608 instead of wrapping.
- R9: Reset (synchronous, active high) clears `run_sum`, `pcm_valid` and the differential encoder state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | Offers a new frame |
| frame_mag | input | 42 | Six 7-bit magnitude codes, slot 0 in the low bits |
| frame_idx | input | 48 | Six 8-bit mapper indices, slot 0 in the low bits |
| user_signs | input | 6 | User sign bits, bit 0 first in time |
| user_count | input | 3 | Number of user sign bits S (0..6) |
| pcm_valid | output | 1 | An octet is present |
| pcm_slot | output | 3 | Slot number of the present octet |
| pcm_comp | output | 1 | Present slot is a compensation slot |
| pcm_out | output | 8 | Signed octet: sign in bit 7, magnitude in bits 6..0 |
| run_sum | output | 24 | Running linear sum of emitted codes |

## Verification
Saturation of the running sum is the state that is hardest to reach from the ports. It only appears after more than a thousand codes of one polarity. The stimulus gets there by sending full-scale codes with six user signs per frame. The first user bit is set so the differential chain settles at positive, and every later bit is zero, so the sum climbs by 8031 per code until it pins at the limit. A second hard case is a frame offered while the unit is busy. The bench injects a frame with six set user bits in the middle of a frame. That frame would flip the encoder state if it were taken, and the next real frame shows that it was not.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int SLOTS  = 6;
    localparam int MAG_W  = 7;
    localparam int LIN_W  = 13;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CNT_W  = $clog2(SLOTS + 1);

    typedef struct packed {
        logic             positive;
        logic [MAG_W-1:0] mag;
    } pcm_octet_t;

    // mu-law magnitude expansion: ((2q+33) << e) - 33
    function automatic logic [LIN_W-1:0] mu_expand(input logic [MAG_W-1:0] code);
        logic [LIN_W-1:0] base;
        base = LIN_W'({code[3:0], 1'b1}) + LIN_W'(32);
        return (base << code[6:4]) - LIN_W'(33);
    endfunction

endpackage

// File: rtl/dcs_comp_select.sv
module dcs_comp_select
    import dcs_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [SLOTS*IDX_W-1:0] idx_flat,
    input  logic [CNT_W-1:0]       comp_count,
    output logic [SLOTS-1:0]       comp_mask
);
    logic [IDX_W-1:0] idx [SLOTS];

    for (genvar k = 0; k < SLOTS; k++) begin : g_unpack
        assign idx[k] = idx_flat[k*IDX_W +: IDX_W];
    end

    // A slot's rank counts the slots that win over it: smaller index,
    // or equal index at a later position.
    for (genvar i = 0; i < SLOTS; i++) begin : g_rank
        logic [CNT_W-1:0] rank;
        always_comb begin
            rank = '0;
            for (int j = 0; j < SLOTS; j++) begin
                if (j != i) begin
                    if ((idx[j] < idx[i]) || ((idx[j] == idx[i]) && (j > i)))
                        rank = rank + CNT_W'(1);
                end
            end
        end
        assign comp_mask[i] = (rank < comp_count);
    end

endmodule

// File: rtl/dcs_sign_steer.sv
module dcs_sign_steer
    import dcs_pkg::*;
(
    input  logic [SLOTS-1:0] usr_bits,
    input  logic [CNT_W-1:0] usr_count,
    input  logic             prev_enc,
    input  logic [SLOTS-1:0] comp_mask,
    output logic [SLOTS-1:0] slot_sign,
    output logic             next_enc
);
    logic [SLOTS-1:0] enc;

    always_comb begin
        logic acc;
        acc = prev_enc;
        for (int j = 0; j < SLOTS; j++) begin
            acc    = acc ^ usr_bits[j];
            enc[j] = acc;
        end
    end

    always_comb begin
        next_enc = prev_enc;
        for (int j = 0; j < SLOTS; j++) begin
            if (usr_count == CNT_W'(j + 1))
                next_enc = enc[j];
        end
    end

    // Each free slot takes the encoded sign whose order matches its
    // position among the free slots.
    always_comb begin
        logic [CNT_W-1:0] pos;
        for (int i = 0; i < SLOTS; i++) begin
            pos = '0;
            for (int j = 0; j < i; j++) begin
                if (!comp_mask[j])
                    pos = pos + CNT_W'(1);
            end
            slot_sign[i] = 1'b0;
            for (int k = 0; k < SLOTS; k++) begin
                if (pos == CNT_W'(k))
                    slot_sign[i] = enc[k];
            end
        end
    end

endmodule

// File: rtl/dcs_run_sum.sv
module dcs_run_sum
    import dcs_pkg::*;
#(
    parameter int SUM_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    add_en,
    input  logic                    add_neg,
    input  logic [LIN_W-1:0]        lin,
    output logic signed [SUM_W-1:0] sum
);
    localparam logic signed [SUM_W:0] MAX_V = (SUM_W+1)'((1 << (SUM_W-1)) - 1);
    localparam logic signed [SUM_W:0] MIN_V = -(SUM_W+1)'(1 << (SUM_W-1));

    logic signed [SUM_W:0] ext_lin;
    logic signed [SUM_W:0] nxt;

    always_comb begin
        ext_lin = $signed({{(SUM_W+1-LIN_W){1'b0}}, lin});
        nxt     = $signed({sum[SUM_W-1], sum}) + (add_neg ? -ext_lin : ext_lin);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
        end else if (add_en) begin
            if (nxt > MAX_V)
                sum <= MAX_V[SUM_W-1:0];
            else if (nxt < MIN_V)
                sum <= MIN_V[SUM_W-1:0];
            else
                sum <= nxt[SUM_W-1:0];
        end
    end

endmodule

// File: rtl/dcs_sign_unit.sv
module dcs_sign_unit
    import dcs_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int SUM_W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_valid,
    input  logic [SLOTS*MAG_W-1:0] frame_mag,
    input  logic [SLOTS*IDX_W-1:0] frame_idx,
    input  logic [SLOTS-1:0]       user_signs,
    input  logic [CNT_W-1:0]       user_count,
    output logic                   pcm_valid,
    output logic [SLOT_W-1:0]      pcm_slot,
    output logic                   pcm_comp,
    output logic [7:0]             pcm_out,
    output logic [SUM_W-1:0]       run_sum
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic             active;
    logic [SLOT_W-1:0] slot_q;
    logic [MAG_W-1:0] mag_q [SLOTS];
    logic [SLOTS-1:0] comp_q;
    logic [SLOTS-1:0] usign_q;
    logic             enc_state;

    logic             accept;
    logic [CNT_W-1:0] usr_cnt;
    logic [CNT_W-1:0] comp_cnt;
    logic [SLOTS-1:0] comp_mask;
    logic [SLOTS-1:0] slot_sign;
    logic             next_enc;

    pcm_octet_t       cur;
    logic             cur_comp;
    logic [LIN_W-1:0] cur_lin;
    logic signed [SUM_W-1:0] sum_s;

    assign accept   = frame_valid && !active;
    assign usr_cnt  = (user_count > CNT_W'(SLOTS)) ? CNT_W'(SLOTS) : user_count;
    assign comp_cnt = CNT_W'(SLOTS) - usr_cnt;

    dcs_comp_select #(.IDX_W(IDX_W)) u_sel (
        .idx_flat   (frame_idx),
        .comp_count (comp_cnt),
        .comp_mask  (comp_mask)
    );

    dcs_sign_steer u_steer (
        .usr_bits  (user_signs),
        .usr_count (usr_cnt),
        .prev_enc  (enc_state),
        .comp_mask (comp_mask),
        .slot_sign (slot_sign),
        .next_enc  (next_enc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            slot_q    <= '0;
            comp_q    <= '0;
            usign_q   <= '0;
            enc_state <= 1'b0;
            for (int k = 0; k < SLOTS; k++) mag_q[k] <= '0;
        end else if (accept) begin
            active    <= 1'b1;
            slot_q    <= '0;
            comp_q    <= comp_mask;
            usign_q   <= slot_sign;
            enc_state <= next_enc;
            for (int k = 0; k < SLOTS; k++) mag_q[k] <= frame_mag[k*MAG_W +: MAG_W];
        end else if (active) begin
            if (slot_q == LAST_SLOT) begin
                active <= 1'b0;
                slot_q <= '0;
            end else begin
                slot_q <= slot_q + SLOT_W'(1);
            end
        end
    end

    always_comb begin
        cur_comp = 1'b0;
        cur.mag  = '0;
        cur.positive = 1'b0;
        for (int k = 0; k < SLOTS; k++) begin
            if (slot_q == SLOT_W'(k)) begin
                cur_comp     = comp_q[k];
                cur.mag      = mag_q[k];
                cur.positive = comp_q[k] ? sum_s[SUM_W-1] : usign_q[k];
            end
        end
        cur_lin = mu_expand(cur.mag);
    end

    dcs_run_sum #(.SUM_W(SUM_W)) u_sum (
        .clk     (clk),
        .rst     (rst),
        .add_en  (active),
        .add_neg (!cur.positive),
        .lin     (cur_lin),
        .sum     (sum_s)
    );

    assign pcm_valid = active;
    assign pcm_slot  = slot_q;
    assign pcm_comp  = active && cur_comp;
    assign pcm_out   = cur;
    assign run_sum   = sum_s;

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker
    import dcs_pkg::*;
#(
    parameter int SUM_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              pcm_valid,
    input logic [SLOT_W-1:0] pcm_slot,
    input logic              pcm_comp,
    input logic [7:0]        pcm_out,
    input logic [SUM_W-1:0]  run_sum
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    a_r1_slot_range: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> (pcm_slot <= LAST));

    a_r1_slot_step: assert property (@(posedge clk) disable iff (rst)
        (pcm_valid && pcm_slot != LAST) |=>
            (pcm_valid && pcm_slot == SLOT_W'($past(pcm_slot) + SLOT_W'(1))));

    a_r1_frame_end: assert property (@(posedge clk) disable iff (rst)
        (pcm_valid && pcm_slot == LAST) |=> !pcm_valid);

    a_r6_comp_sign: assert property (@(posedge clk) disable iff (rst)
        (pcm_valid && pcm_comp) |-> (pcm_out[7] == run_sum[SUM_W-1]));

    a_r7_sum_hold: assert property (@(posedge clk) disable iff (rst)
        !pcm_valid |=> $stable(run_sum));

    a_r8_no_wrap_pos: assert property (@(posedge clk) disable iff (rst)
        (pcm_valid && !run_sum[SUM_W-1] && pcm_out[7]) |=> !run_sum[SUM_W-1]);

    a_r8_no_wrap_neg: assert property (@(posedge clk) disable iff (rst)
        (pcm_valid && run_sum[SUM_W-1] && !pcm_out[7]) |=> run_sum[SUM_W-1]);

endmodule

bind dcs_sign_unit dcs_checker #(.SUM_W(SUM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pcm_valid (pcm_valid),
    .pcm_slot  (pcm_slot),
    .pcm_comp  (pcm_comp),
    .pcm_out   (pcm_out),
    .run_sum   (run_sum)
);

// File: tb/dcs_sign_unit_test.sv
module dcs_sign_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_valid = 1'b0;
    logic [41:0] frame_mag = '0;
    logic [47:0] frame_idx = '0;
    logic [5:0]  user_signs = '0;
    logic [2:0]  user_count = '0;
    logic        pcm_valid;
    logic [2:0]  pcm_slot;
    logic        pcm_comp;
    logic [7:0]  pcm_out;
    logic [23:0] run_sum;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // model state
    int m_prev = 0;
    longint m_sum = 0;

    always #10 clk = ~clk;

    dcs_sign_unit uut (
        .clk(clk), .rst(rst), .frame_valid(frame_valid),
        .frame_mag(frame_mag), .frame_idx(frame_idx),
        .user_signs(user_signs), .user_count(user_count),
        .pcm_valid(pcm_valid), .pcm_slot(pcm_slot), .pcm_comp(pcm_comp),
        .pcm_out(pcm_out), .run_sum(run_sum)
    );

    // vector: {mags 42, idx 48, user bits 6, user count 3}
    localparam logic [98:0] VECS [0:7] = '{
        {{7'd60,7'd50,7'd40,7'd30,7'd20,7'd10}, {8'd9,8'd5,8'd1,8'd4,8'd1,8'd3}, 6'b000101, 3'd3},
        {{7'h66,7'h11,7'h2A,7'h55,7'h00,7'h7F}, {8'd0,8'd0,8'd0,8'd0,8'd0,8'd0}, 6'b111111, 3'd6},
        {{7'h70,7'h61,7'h52,7'h43,7'h34,7'h25}, {8'd2,8'd3,8'd4,8'd5,8'd6,8'd7}, 6'b000000, 3'd0},
        {{7'h0F,7'h1E,7'h2D,7'h3C,7'h4B,7'h5A}, {8'd8,8'd1,8'd1,8'd9,8'd2,8'd2}, 6'b000010, 3'd2},
        {{7'h33,7'h44,7'h55,7'h66,7'h77,7'h08}, {8'd0,8'd10,8'd30,8'd10,8'd10,8'd20}, 6'b001010, 3'd4},
        {{7'h7F,7'h7E,7'h01,7'h02,7'h40,7'h41}, {8'd200,8'd3,8'd3,8'd7,8'd1,8'd9}, 6'b000001, 3'd1},
        {{7'h12,7'h23,7'h34,7'h45,7'h56,7'h67}, {8'd6,8'd5,8'd4,8'd3,8'd2,8'd1}, 6'b010110, 3'd5},
        {{7'h09,7'h19,7'h29,7'h39,7'h49,7'h59}, {8'd5,8'd5,8'd5,8'd5,8'd5,8'd5}, 6'b000010, 3'd3}
    };

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint lin_of(input int code);
        int e, q;
        e = (code >> 4) & 7;
        q = code & 15;
        return longint'((q * 2 + 33) * (1 << e) - 33);
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        frame_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_prev = 0;
        m_sum = 0;
    endtask

    // Drive one frame and check every octet; inject offers a foreign
    // frame while the unit is busy (it must be ignored, R1).
    task automatic run_frame(input logic [41:0] mags, input logic [47:0] idxs,
                             input logic [5:0] usr, input int s, input bit inject,
                             input bit full_check);
        int     picked [6];
        int     enc [6];
        int     d, p, best, sdc;
        int     exp_sign [6];
        bit     ssign;
        for (int i = 0; i < 6; i++) picked[i] = 0;
        sdc = 6 - s;
        for (int k = 0; k < sdc; k++) begin
            best = -1;
            for (int j = 5; j >= 0; j--) begin
                if (!picked[j] && (best < 0 || idxs[j*8 +: 8] < idxs[best*8 +: 8]))
                    best = j;
            end
            picked[best] = 1;
        end
        d = m_prev;
        for (int j = 0; j < 6; j++) begin
            enc[j] = 0;
            if (j < s) begin
                d = d ^ int'(usr[j]);
                enc[j] = d;
            end
        end
        if (s > 0) m_prev = enc[s-1];
        p = 0;
        for (int i = 0; i < 6; i++) begin
            if (!picked[i]) begin
                exp_sign[i] = enc[p];
                p++;
            end else begin
                exp_sign[i] = -1;
            end
        end

        frame_mag = mags; frame_idx = idxs; user_signs = usr; user_count = 3'(s);
        frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (exp_sign[k] < 0) ssign = (m_sum < 0);
            else                 ssign = bit'(exp_sign[k]);
            if (full_check || k == 0) begin
                check("R1 valid", pcm_valid, 1);
                check("R1 slot", pcm_slot, k);
                check("R2 magnitude", pcm_out[6:0], mags[k*7 +: 7]);
                check("R5 comp flag", pcm_comp, picked[k]);
                if (picked[k]) check("R6 comp sign", pcm_out[7], ssign);
                else           check("R3 R4 user sign", pcm_out[7], ssign);
                check("R7 running sum", longint'($signed(run_sum)), m_sum);
            end
            m_sum = m_sum + (ssign ? lin_of(int'(mags[k*7 +: 7])) : -lin_of(int'(mags[k*7 +: 7])));
            if (m_sum > 64'sd8388607)  m_sum = 64'sd8388607;
            if (m_sum < -64'sd8388608) m_sum = -64'sd8388608;
            if (inject && k == 2) begin
                frame_mag = '1; frame_idx = '0; user_signs = 6'b111111; user_count = 3'd6;
                frame_valid = 1'b1;
            end else begin
                frame_valid = 1'b0;
            end
            @(negedge clk);
        end
        frame_valid = 1'b0;
        if (full_check) begin
            check("R1 idle after frame", pcm_valid, 0);
            check("R7 sum after frame", longint'($signed(run_sum)), m_sum);
        end
    endtask

    initial begin
        do_reset();
        // R9 reset state
        check("R9 valid after reset", pcm_valid, 0);
        check("R9 sum after reset", run_sum, 0);
        // R3: reset encoder state is 0, so zero user bits give negative signs
        run_frame({7'h10,7'h10,7'h10,7'h10,7'h10,7'h10}, 48'h0, 6'b000000, 6, 0, 1);
        check("R3 reset encoder gives negative", pcm_out[7], 0);

        do_reset();
        // R6: sum of zero picks negative compensation; R5 ties pick later slots
        run_frame({7'h20,7'h21,7'h22,7'h23,7'h24,7'h25}, 48'h0, 6'b000000, 0, 0, 1);

        // table walk
        for (int v = 0; v < 8; v++) begin
            run_frame(VECS[v][98:57], VECS[v][56:9], VECS[v][8:3], int'(VECS[v][2:0]), 0, 1);
            @(negedge clk);
        end

        // R1: frame offered while busy is ignored (encoder state untouched)
        run_frame({7'h31,7'h32,7'h33,7'h34,7'h35,7'h36}, 48'h050403020100, 6'b001011, 4, 1, 1);
        @(negedge clk);
        check("R1 ignored frame not started", pcm_valid, 0);
        run_frame({7'h01,7'h02,7'h03,7'h04,7'h05,7'h06}, 48'h0, 6'b000000, 6, 0, 1);

        // R8: drive sum to positive saturation
        do_reset();
        run_frame({6{7'h7F}}, 48'h0, 6'b000001, 6, 0, 0);
        for (int f = 0; f < 180; f++)
            run_frame({6{7'h7F}}, 48'h0, 6'b000000, 6, 0, 0);
        check("R8 saturated high", longint'($signed(run_sum)), 64'sd8388607);
        check("R8 model at limit", m_sum, 64'sd8388607);
        // one more frame while pinned: all positive, still at limit
        run_frame({6{7'h7F}}, 48'h0, 6'b000000, 6, 0, 1);
        check("R8 held at limit", longint'($signed(run_sum)), 64'sd8388607);
        // a negative frame pulls it down from the limit
        run_frame({6{7'h7F}}, 48'h0, 6'b000001, 6, 0, 1);
        check("R8 leaves limit", longint'($signed(run_sum)), 64'sd8388607 - 6 * 8031);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule